// File: doc/BRIEF.md
# Variable-Length Displacement Decoder

This block turns the bytes of a packed displacement field into a signed 32-bit offset and reports the field's length in bytes. The two top bits of the first byte give the length. If bit 7 is clear, the field is a single byte carrying a 7-bit signed payload. The prefix `10` selects a two-byte field with a 14-bit payload. The prefix `11` selects a four-byte field with a 30-bit payload. The byte that arrives first always holds the most significant part of the payload. The decoded value is the payload sign-extended to 32 bits.

Bytes can be presented in two ways, chosen per field by `stream_mode` when the first byte is taken. In window mode (`stream_mode`=0) a whole four-byte window is given in one cycle, and the block decodes it combinationally in that cycle. In streaming mode (`stream_mode`=1) one byte per valid cycle arrives on `in_data[7:0]` and is gathered until the field is complete. In both modes the next valid input after a completed field is taken as the first byte of a new field.

The result appears with `done` in the cycle that completes a field. It then stays on the outputs until the next field completes. Address arithmetic and memory fetch belong to the surrounding logic.

Top module: `disp_decoder`

## Requirements
- R1: A first byte with bit 7 = 0 gives `disp_len` = 1 and `disp_value` = bits [6:0] of that byte sign-extended from bit 6.
- R2: A first byte with bits [7:6] = 10 gives `disp_len` = 2 and `disp_value` = {first[5:0], second[7:0]} sign-extended from bit 13.
- R3: A first byte with bits [7:6] = 11 gives `disp_len` = 4 and `disp_value` = {first[5:0], second, third, fourth} sign-extended from bit 29.
- R4: Byte order is most-significant first. In window mode, `in_data[7:0]` is the first byte, `[15:8]` the second, `[23:16]` the third and `[31:24]` the fourth.
- R5: In window mode, a valid input while no field is in progress completes a field in the same cycle (`done`=1). Window bytes beyond the decoded length have no effect on the result.
- R6: In streaming mode, only `in_data[7:0]` is used, and cycles with `in_valid`=0 are waited through. `done` is 1 only in the cycle in which the last byte of the field is accepted, and it is 0 while earlier bytes are accepted.
- R7: Fields follow each other with no gap. The first valid byte after a completed field starts a new field, whatever the previous field's length was.
- R8: When `done` is 0, `disp_value` and `disp_len` keep the values of the most recently completed field. This includes cycles in which the first or middle bytes of a streamed field are accepted.
- R9: While `rst` is 1, the block returns to waiting for a first byte and discards any partly gathered field. Once `rst` goes back to 0, `disp_value` and `disp_len` read 0 until a field completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bytes are valid this cycle |
| stream_mode | input | 1 | 0: whole window per cycle, 1: one byte per cycle; sampled on a first byte |
| in_data | input | 32 | Byte window, first byte in [7:0]; only [7:0] used when streaming |
| disp_value | output | 32 | Sign-extended displacement |
| disp_len | output | 3 | Field length in bytes (1, 2 or 4) |
| done | output | 1 | A field completes in this cycle |

## Verification
Suppose the byte-gathering state or the remaining-byte count goes wrong inside the block. Then `done` fires too early or too late within a streamed field, and the next field then starts on the wrong byte. A single misplaced byte therefore shows up as a wrong value or length on the very next completed field. A fault in the hold register shows up in the first idle cycle after `done`, because the outputs then change without a new field. The scenarios stream fields with gaps, back-to-back and interrupted by reset, so that each of these shows up within a few cycles.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int BYTE_W    = 8;
    localparam int WIN_BYTES = 4;
    localparam int WIN_W     = BYTE_W * WIN_BYTES;
    localparam int LEN_W     = $clog2(WIN_BYTES) + 1;
    localparam int CNT_W     = $clog2(WIN_BYTES);

    localparam int PAY_ONE   = BYTE_W - 1;
    localparam int PAY_TWO   = 2 * BYTE_W - 2;
    localparam int PAY_FOUR  = 4 * BYTE_W - 2;

    typedef enum logic [1:0] {
        CLS_ONE  = 2'd0,
        CLS_TWO  = 2'd1,
        CLS_FOUR = 2'd2
    } disp_cls_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } gather_st_e;

    function automatic disp_cls_e classify_byte(input logic [BYTE_W-1:0] b);
        if (!b[BYTE_W-1])      return CLS_ONE;
        else if (!b[BYTE_W-2]) return CLS_TWO;
        else                   return CLS_FOUR;
    endfunction

    function automatic logic [LEN_W-1:0] cls_bytes(input disp_cls_e c);
        case (c)
            CLS_ONE:  return LEN_W'(1);
            CLS_TWO:  return LEN_W'(2);
            default:  return LEN_W'(4);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] cls_more(input disp_cls_e c);
        return CNT_W'(cls_bytes(c) - LEN_W'(1));
    endfunction

    function automatic logic [WIN_W-1:0] sext_from(input logic [WIN_W-1:0] raw,
                                                   input int bits);
        logic [WIN_W-1:0] r;
        for (int i = 0; i < WIN_W; i++)
            r[i] = (i < bits) ? raw[i] : raw[bits-1];
        return r;
    endfunction

endpackage

// File: rtl/disp_classify.sv
module disp_classify
    import disp_pkg::*;
(
    input  logic [BYTE_W-1:0] first_byte,
    output disp_cls_e         cls
);
    always_comb cls = classify_byte(first_byte);
endmodule

// File: rtl/disp_assemble.sv
module disp_assemble
    import disp_pkg::*;
(
    input  logic [WIN_W-1:0] word_be,
    input  disp_cls_e        cls,
    output logic [WIN_W-1:0] value
);
    logic [WIN_W-1:0] raw;

    always_comb begin
        raw = '0;
        case (cls)
            CLS_ONE: begin
                raw[PAY_ONE-1:0] = word_be[WIN_W-2 -: PAY_ONE];
                value = sext_from(raw, PAY_ONE);
            end
            CLS_TWO: begin
                raw[PAY_TWO-1:0] = word_be[WIN_W-3 -: PAY_TWO];
                value = sext_from(raw, PAY_TWO);
            end
            default: begin
                raw[PAY_FOUR-1:0] = word_be[WIN_W-3 -: PAY_FOUR];
                value = sext_from(raw, PAY_FOUR);
            end
        endcase
    end
endmodule

// File: rtl/disp_stream_ctrl.sv
module disp_stream_ctrl
    import disp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             stream_mode,
    input  logic [WIN_W-1:0] in_data,
    input  disp_cls_e        first_cls,
    output logic             field_done,
    output logic [WIN_W-1:0] word_be,
    output disp_cls_e        done_cls
);
    localparam int ACC_W = WIN_W - BYTE_W;

    gather_st_e         state;
    logic [ACC_W-1:0]   acc;
    logic [CNT_W-1:0]   remaining;
    disp_cls_e          cur_cls;
    logic [WIN_W-1:0]   win_be;
    logic [BYTE_W-1:0]  cur_byte;

    assign cur_byte = in_data[BYTE_W-1:0];

    genvar g;
    generate
        for (g = 0; g < WIN_BYTES; g++) begin : g_swap
            assign win_be[WIN_W-1-BYTE_W*g -: BYTE_W] = in_data[BYTE_W*g +: BYTE_W];
        end
    endgenerate

    always_comb begin
        field_done = 1'b0;
        word_be    = '0;
        done_cls   = first_cls;
        if (state == ST_IDLE && in_valid) begin
            if (!stream_mode) begin
                field_done = 1'b1;
                word_be    = win_be;
            end else if (first_cls == CLS_ONE) begin
                field_done = 1'b1;
                word_be    = {cur_byte, {ACC_W{1'b0}}};
            end
        end else if (state == ST_COLLECT && in_valid && remaining == CNT_W'(1)) begin
            field_done = 1'b1;
            done_cls   = cur_cls;
            if (cur_cls == CLS_TWO)
                word_be = {acc[BYTE_W-1:0], cur_byte, {(WIN_W-2*BYTE_W){1'b0}}};
            else
                word_be = {acc, cur_byte};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            acc       <= '0;
            remaining <= '0;
            cur_cls   <= CLS_ONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_valid && stream_mode && first_cls != CLS_ONE) begin
                        state     <= ST_COLLECT;
                        acc       <= {{(ACC_W-BYTE_W){1'b0}}, cur_byte};
                        remaining <= cls_more(first_cls);
                        cur_cls   <= first_cls;
                    end
                end
                default: begin
                    if (in_valid) begin
                        acc       <= {acc[ACC_W-BYTE_W-1:0], cur_byte};
                        remaining <= remaining - CNT_W'(1);
                        if (remaining == CNT_W'(1))
                            state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    AST_COLLECT_COUNT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COLLECT) |-> (remaining != '0 && cur_cls != CLS_ONE)); // R6
    AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        field_done |-> in_valid); // R6
    AST_RESET_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_IDLE)); // R9
    AST_NEXT_FIELD_FRESH: assert property (@(posedge clk) disable iff (rst)
        field_done |=> (state == ST_IDLE)); // R7
endmodule

// File: rtl/disp_decoder.sv
module disp_decoder
    import disp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             stream_mode,
    input  logic [31:0]      in_data,
    output logic [31:0]      disp_value,
    output logic [2:0]       disp_len,
    output logic             done
);
    disp_cls_e          first_cls;
    disp_cls_e          done_cls;
    logic               field_done;
    logic [WIN_W-1:0]   word_be;
    logic [WIN_W-1:0]   asm_val;
    logic [WIN_W-1:0]   held_val;
    logic [LEN_W-1:0]   held_len;

    disp_classify u_cls (
        .first_byte (in_data[BYTE_W-1:0]),
        .cls        (first_cls)
    );

    disp_stream_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .stream_mode (stream_mode),
        .in_data     (in_data),
        .first_cls   (first_cls),
        .field_done  (field_done),
        .word_be     (word_be),
        .done_cls    (done_cls)
    );

    disp_assemble u_asm (
        .word_be (word_be),
        .cls     (done_cls),
        .value   (asm_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_val <= '0;
            held_len <= '0;
        end else if (field_done) begin
            held_val <= asm_val;
            held_len <= cls_bytes(done_cls);
        end
    end

    assign done       = field_done;
    assign disp_value = field_done ? asm_val : held_val;
    assign disp_len   = field_done ? cls_bytes(done_cls) : held_len;

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (disp_len == 3'd1 || disp_len == 3'd2 || disp_len == 3'd4)); // R7
    AST_ONE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (done && disp_len == 3'd1) |-> (disp_value[31:6] == '0 || disp_value[31:6] == '1)); // R1
    AST_TWO_SIGN: assert property (@(posedge clk) disable iff (rst)
        (done && disp_len == 3'd2) |-> (disp_value[31:13] == '0 || disp_value[31:13] == '1)); // R2
    AST_FOUR_SIGN: assert property (@(posedge clk) disable iff (rst)
        (done && disp_len == 3'd4) |-> (disp_value[31:29] == '0 || disp_value[31:29] == '1)); // R3
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (done || ($stable(disp_value) && $stable(disp_len)))); // R8
endmodule

// File: tb/sim_disp_decoder.sv
module sim_disp_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        stream_mode;
    logic [31:0] in_data;
    logic [31:0] disp_value;
    logic [2:0]  disp_len;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    disp_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .stream_mode(stream_mode),
        .in_data(in_data), .disp_value(disp_value), .disp_len(disp_len), .done(done)
    );

    function automatic int model_len(input logic [7:0] b0);
        if (b0[7] == 1'b0) return 1;
        if (b0[6] == 1'b0) return 2;
        return 4;
    endfunction

    function automatic logic [31:0] model_val(input logic [7:0] b0, b1, b2, b3);
        longint v;
        case (model_len(b0))
            1: begin v = longint'(b0[6:0]); if (v >= 64) v -= 128; end
            2: begin v = longint'({b0[5:0], b1}); if (v >= 8192) v -= 16384; end
            default: begin
                v = longint'({b0[5:0], b1, b2, b3});
                if (v >= 64'sd536870912) v -= 64'sd1073741824;
            end
        endcase
        return v[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic m, input logic [31:0] d);
        @(negedge clk);
        in_valid = v; stream_mode = m; in_data = d;
        #1;
    endtask

    task automatic idle();
        apply(1'b0, 1'b0, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; stream_mode = 1'b0; in_data = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic win_case(input string req, input logic [7:0] b0, b1, b2, b3);
        apply(1'b1, 1'b0, {b3, b2, b1, b0});
        check({req, " done"}, 32'(done), 32'd1);
        check({req, " len"}, 32'(disp_len), 32'(model_len(b0)));
        check({req, " value"}, disp_value, model_val(b0, b1, b2, b3));
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R9 done after reset", 32'(done), 32'd0);
        check("R9 value after reset", disp_value, 32'd0);
        check("R9 len after reset", 32'(disp_len), 32'd0);
    endtask

    task automatic t_window_one();
        win_case("R1 pos", 8'h05, 8'h00, 8'h00, 8'h00);
        win_case("R1 neg one", 8'h7F, 8'h00, 8'h00, 8'h00);
        win_case("R1 min", 8'h40, 8'h00, 8'h00, 8'h00);
        check("R1 min literal", disp_value, 32'hFFFF_FFC0);
    endtask

    task automatic t_window_two();
        win_case("R2 pos", 8'h81, 8'h23, 8'h00, 8'h00);
        check("R4 two order", disp_value, 32'h0000_0123);
        win_case("R2 neg one", 8'hBF, 8'hFF, 8'h00, 8'h00);
        win_case("R2 min", 8'hA0, 8'h00, 8'h00, 8'h00);
        check("R2 min literal", disp_value, 32'hFFFF_E000);
    endtask

    task automatic t_window_four();
        win_case("R3 pos", 8'hC1, 8'h23, 8'h45, 8'h67);
        check("R4 four order", disp_value, 32'h0123_4567);
        win_case("R3 min", 8'hE0, 8'h00, 8'h00, 8'h00);
        check("R3 min literal", disp_value, 32'hE000_0000);
    endtask

    task automatic t_window_ignore();
        win_case("R5 one garbage", 8'h05, 8'hFF, 8'hFF, 8'hFF);
        check("R5 one garbage literal", disp_value, 32'd5);
        win_case("R5 two garbage", 8'h81, 8'h23, 8'hAA, 8'h55);
        check("R5 two garbage literal", disp_value, 32'h0000_0123);
    endtask

    task automatic t_stream_gap();
        win_case("R7 prior", 8'h11, 8'h00, 8'h00, 8'h00);
        apply(1'b1, 1'b1, 32'hFFFF_FF81);
        check("R6 no done on first", 32'(done), 32'd0);
        check("R8 held during first", disp_value, 32'h11);
        idle();
        check("R6 no done on gap", 32'(done), 32'd0);
        apply(1'b1, 1'b1, 32'hFFFF_FF23);
        check("R6 done on last", 32'(done), 32'd1);
        check("R6 value", disp_value, 32'h0000_0123);
        check("R6 len", 32'(disp_len), 32'd2);
    endtask

    task automatic t_stream_four();
        logic [7:0] bs [4];
        bs[0] = 8'hFE; bs[1] = 8'hDC; bs[2] = 8'hBA; bs[3] = 8'h98;
        for (int i = 0; i < 4; i++) begin
            apply(1'b1, 1'b1, {24'h0, bs[i]});
            check("R6 four done timing", 32'(done), (i == 3) ? 32'd1 : 32'd0);
        end
        check("R3 stream four value", disp_value, model_val(bs[0], bs[1], bs[2], bs[3]));
        check("R3 stream four len", 32'(disp_len), 32'd4);
    endtask

    task automatic t_back_to_back();
        apply(1'b1, 1'b1, 32'h05);
        check("R7 b2b first done", 32'(done), 32'd1);
        check("R7 b2b first value", disp_value, 32'd5);
        apply(1'b1, 1'b1, 32'hBF);
        check("R7 b2b second start", 32'(done), 32'd0);
        apply(1'b1, 1'b0, 32'hFE);
        check("R7 b2b second done", 32'(done), 32'd1);
        check("R7 b2b second value", disp_value, model_val(8'hBF, 8'hFE, 8'h0, 8'h0));
        apply(1'b1, 1'b0, 32'h0000_2381);
        check("R7 b2b third window", disp_value, 32'h0000_0123);
    endtask

    task automatic t_hold();
        win_case("R8 set", 8'hC0, 8'h00, 8'h01, 8'h00);
        for (int i = 0; i < 3; i++) begin
            idle();
            check("R8 hold value", disp_value, 32'h0000_0100);
            check("R8 hold len", 32'(disp_len), 32'd4);
            check("R8 hold done", 32'(done), 32'd0);
        end
    endtask

    task automatic t_reset_mid();
        apply(1'b1, 1'b1, 32'hC1);
        apply(1'b1, 1'b1, 32'h23);
        do_reset();
        check("R9 value cleared", disp_value, 32'd0);
        apply(1'b1, 1'b1, 32'h05);
        check("R9 fresh start done", 32'(done), 32'd1);
        check("R9 fresh start value", disp_value, 32'd5);
        check("R9 fresh start len", 32'(disp_len), 32'd1);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; stream_mode = 1'b0; in_data = '0;
        t_reset_state();
        t_window_one();
        t_window_two();
        t_window_four();
        t_window_ignore();
        t_stream_gap();
        t_stream_four();
        t_back_to_back();
        t_hold();
        t_reset_mid();
        idle();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule